// File: doc/BRIEF.md
# Firmware Glue-Logic Register Block

This block is a small memory-mapped slave that collects the odd jobs firmware needs on a multiprocessor board into one 32-byte window. Through it, firmware can:

- request a halt together with an exit code;
- learn which processor it is running on and how many processors exist;
- drive one level-sensitive interrupt line per processor;
- move single characters to and from a console.

The bus port is synchronous. The bus presents a select, a write flag, an address, a byte count, write data and the index of the requesting processor. Read data is combinational and valid in the same cycle as the select. Writes, and the side effect of a status read, take effect at the clock edge that ends the access.

The console receive side is a valid flag and a character. A read of the input status register samples them. The transmit side is a one-cycle strobe that carries the character with it. The halt request is also a one-cycle pulse, and its exit code stays on its output afterwards. Only the low five address bits are decoded, so the window repeats through the rest of the address space.

Top module: `fw_glue_regs`

## Requirements
- R1: Only address bits [4:0] are decoded; an access at any address behaves exactly as the access at that address with the upper bits cleared.
- R2: A write to offset 0x00 makes `haltPulse` high for exactly the one cycle after the write edge, and `haltCode` takes write data bits [7:0] at that edge.
- R3: A read of offset 0x04 returns `reqCpu`, zero-extended.
- R4: A read of offset 0x0A returns the parameter NUM_CPU.
- R5: A write to offset 0x08 selects an interrupt line and sets its level:
  - write data bits [7:0] give the line number and bits [15:8] give the level, where nonzero means asserted (so data 0x0102 with two bytes asserts line 2);
  - a one-byte write (`busBytes` = 1) drives the line low;
  - a line number of NUM_CPU or more changes nothing;
  - lines hold their level between writes.
- R6: A read of offset 0x14 samples the receive side:
  - if `rxValid` is high, it returns 1 and, at the edge, latches `rxChar` as the input data;
  - otherwise it returns 0 and clears the input data.
  - The input data reads back at offset 0x10.
- R7: A write to offset 0x18 raises `txStrobe` for exactly one cycle with `txData` equal to write data bits [7:0]. It also sets the output status (offset 0x1A) to 1, and the same byte reads back at offset 0x18.
- R8: Every read returns its value in bits [7:0] with all higher bits zero. Reads of offsets 0x00, 0x08 and any offset not listed in R3 to R7 return 0.
- R9: After reset:
  - the output status reads 1;
  - the input data and output data read 0;
  - all interrupt lines are low;
  - `txStrobe` and `haltPulse` are low.
- R10: A write to offset 0x10 overwrites the input data, and a write to offset 0x1A overwrites the output status, each with write data bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address; bits [4:0] decoded |
| busBytes | input | CNT_W | Number of bytes in the access (1..BUS_BYTES) |
| busWdata | input | DATA_W | Write data; byte 0 in bits [7:0] |
| reqCpu | input | CPU_W | Index of the processor making the access |
| busRdata | output | DATA_W | Read data, combinational |
| rxValid | input | 1 | Console character available |
| rxChar | input | 8 | Console receive character |
| txStrobe | output | 1 | One-cycle console transmit strobe |
| txData | output | 8 | Console transmit character |
| irqLines | output | NUM_CPU | Per-processor interrupt levels |
| haltPulse | output | 1 | One-cycle halt request |
| haltCode | output | 8 | Exit code of the last halt request |

## Verification
The bench targets the following corners, each with the failure it would expose:

- **Interrupt write encoding.** It checks the one-byte form, a zero level and a line number beyond the last processor. A design that reads the level from the wrong byte, ignores the byte count, or wraps an out-of-range line number into the vector would move the wrong interrupt line.
- **Status read side effect.** It reads the input status both with and without a waiting character, then reads the data back. A design that only latches on a hit would leave a stale character where zero is expected.
- **Transmit and status registers.** It checks that an output write forces the status back to 1 after software has cleared it. It also checks that full-width write data comes back with its upper bytes zeroed.
- **Address aliasing.** It accesses registers through aliased addresses, which catches a decoder that looks at more than five bits.

// File: rtl/fw_glue_pkg.sv
package fw_glue_pkg;
  localparam int OFS_W = 5;

  localparam logic [OFS_W-1:0] OFS_HALT   = 5'h00;
  localparam logic [OFS_W-1:0] OFS_CPUID  = 5'h04;
  localparam logic [OFS_W-1:0] OFS_IRQ    = 5'h08;
  localparam logic [OFS_W-1:0] OFS_NCPU   = 5'h0A;
  localparam logic [OFS_W-1:0] OFS_RXDATA = 5'h10;
  localparam logic [OFS_W-1:0] OFS_RXSTAT = 5'h14;
  localparam logic [OFS_W-1:0] OFS_TXDATA = 5'h18;
  localparam logic [OFS_W-1:0] OFS_TXSTAT = 5'h1A;

  typedef enum logic [2:0] {
    RD_ZERO, RD_CPUID, RD_NCPU, RD_RXDATA, RD_RXSTAT, RD_TXDATA, RD_TXSTAT
  } rdSel_e;

  // Strobes from the decoder into the datapath
  typedef struct packed {
    logic haltWr;
    logic irqWr;
    logic rxSample;
    logic rxDataWr;
    logic txDataWr;
    logic txStatWr;
  } ctrlStb_t;
endpackage

// File: rtl/fw_glue_ctrl.sv
module fw_glue_ctrl
  import fw_glue_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStb_t          stb,
  output rdSel_e            rdSel
);
  logic [OFS_W-1:0] ofs;
  logic wrAcc, rdAcc;

  assign ofs   = busAddr[OFS_W-1:0];
  assign wrAcc = busSel & busWrite;
  assign rdAcc = busSel & ~busWrite;

  always_comb begin
    stb   = '0;
    rdSel = RD_ZERO;
    if (wrAcc) begin
      case (ofs)
        OFS_HALT:   stb.haltWr   = 1'b1;
        OFS_IRQ:    stb.irqWr    = 1'b1;
        OFS_RXDATA: stb.rxDataWr = 1'b1;
        OFS_TXDATA: stb.txDataWr = 1'b1;
        OFS_TXSTAT: stb.txStatWr = 1'b1;
        default: ;
      endcase
    end
    if (rdAcc) begin
      case (ofs)
        OFS_CPUID:  rdSel = RD_CPUID;
        OFS_NCPU:   rdSel = RD_NCPU;
        OFS_RXDATA: rdSel = RD_RXDATA;
        OFS_RXSTAT: begin
          rdSel        = RD_RXSTAT;
          stb.rxSample = 1'b1;
        end
        OFS_TXDATA: rdSel = RD_TXDATA;
        OFS_TXSTAT: rdSel = RD_TXSTAT;
        default:    rdSel = RD_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/fw_glue_dp.sv
module fw_glue_dp
  import fw_glue_pkg::*;
#(
  parameter int NUM_CPU   = 4,
  parameter int BUS_BYTES = 4,
  localparam int DATA_W   = 8 * BUS_BYTES,
  localparam int CNT_W    = $clog2(BUS_BYTES + 1),
  localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           stb,
  input  rdSel_e             rdSel,
  input  logic [CNT_W-1:0]   busBytes,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [CPU_W-1:0]   reqCpu,
  output logic [DATA_W-1:0]  busRdata,
  input  logic               rxValid,
  input  logic [7:0]         rxChar,
  output logic               txStrobe,
  output logic [7:0]         txData,
  output logic [NUM_CPU-1:0] irqLines,
  output logic               haltPulse,
  output logic [7:0]         haltCode
);
  localparam logic [7:0] CPU_CNT = 8'(NUM_CPU);

  logic [7:0] wrByte0, wrByte1;
  logic       irqLevel;
  logic [7:0] rxDataQ, txStatQ, rdByte;

  assign wrByte0  = busWdata[7:0];
  assign wrByte1  = busWdata[15:8];
  assign irqLevel = (busBytes > CNT_W'(1)) && (wrByte1 != 8'h00);

  // Console input data and output status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxDataQ <= 8'h00;
      txStatQ <= 8'h01;
    end else begin
      if (stb.rxSample)    rxDataQ <= rxValid ? rxChar : 8'h00;
      else if (stb.rxDataWr) rxDataQ <= wrByte0;
      if (stb.txDataWr)    txStatQ <= 8'h01;
      else if (stb.txStatWr) txStatQ <= wrByte0;
    end
  end

  // Transmit character, strobe and halt request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData    <= 8'h00;
      txStrobe  <= 1'b0;
      haltPulse <= 1'b0;
      haltCode  <= 8'h00;
    end else begin
      txStrobe  <= stb.txDataWr;
      haltPulse <= stb.haltWr;
      if (stb.txDataWr) txData   <= wrByte0;
      if (stb.haltWr)   haltCode <= wrByte0;
    end
  end

  // One level register per interrupt line
  for (genvar g = 0; g < NUM_CPU; g++) begin : gLine
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        irqLines[g] <= 1'b0;
      else if (stb.irqWr && (wrByte0 == 8'(g)))
        irqLines[g] <= irqLevel;
    end
  end

  // Read multiplexer: value in byte 0, the rest zero
  always_comb begin
    rdByte = 8'h00;
    case (rdSel)
      RD_CPUID:  rdByte[CPU_W-1:0] = reqCpu;
      RD_NCPU:   rdByte = CPU_CNT;
      RD_RXDATA: rdByte = rxDataQ;
      RD_RXSTAT: rdByte = {7'd0, rxValid};
      RD_TXDATA: rdByte = txData;
      RD_TXSTAT: rdByte = txStatQ;
      default:   rdByte = 8'h00;
    endcase
  end

  assign busRdata = {{(DATA_W-8){1'b0}}, rdByte};
endmodule

// File: rtl/fw_glue_regs.sv
module fw_glue_regs
  import fw_glue_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_CPU   = 4,
  parameter int BUS_BYTES = 4,
  localparam int DATA_W   = 8 * BUS_BYTES,
  localparam int CNT_W    = $clog2(BUS_BYTES + 1),
  localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [CNT_W-1:0]   busBytes,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [CPU_W-1:0]   reqCpu,
  output logic [DATA_W-1:0]  busRdata,
  input  logic               rxValid,
  input  logic [7:0]         rxChar,
  output logic               txStrobe,
  output logic [7:0]         txData,
  output logic [NUM_CPU-1:0] irqLines,
  output logic               haltPulse,
  output logic [7:0]         haltCode
);
  ctrlStb_t stb;
  rdSel_e   rdSel;

  fw_glue_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .stb     (stb),
    .rdSel   (rdSel)
  );

  fw_glue_dp #(.NUM_CPU(NUM_CPU), .BUS_BYTES(BUS_BYTES)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rdSel    (rdSel),
    .busBytes (busBytes),
    .busWdata (busWdata),
    .reqCpu   (reqCpu),
    .busRdata (busRdata),
    .rxValid  (rxValid),
    .rxChar   (rxChar),
    .txStrobe (txStrobe),
    .txData   (txData),
    .irqLines (irqLines),
    .haltPulse(haltPulse),
    .haltCode (haltCode)
  );
endmodule

// File: rtl/fw_glue_regs_chk.sv
module fw_glue_regs_chk #(
  parameter int ADDR_W    = 8,
  parameter int NUM_CPU   = 4,
  parameter int BUS_BYTES = 4,
  localparam int DATA_W   = 8 * BUS_BYTES,
  localparam int CNT_W    = $clog2(BUS_BYTES + 1),
  localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [CNT_W-1:0]   busBytes,
  input logic [DATA_W-1:0]  busWdata,
  input logic [CPU_W-1:0]   reqCpu,
  input logic [DATA_W-1:0]  busRdata,
  input logic               rxValid,
  input logic [7:0]         rxChar,
  input logic               txStrobe,
  input logic [7:0]         txData,
  input logic [NUM_CPU-1:0] irqLines,
  input logic               haltPulse,
  input logic [7:0]         haltCode
);
  logic wrIn, rdIn, haltWrIn, irqWrIn, txWrIn, cpuRdIn, cntRdIn;

  assign wrIn     = busSel && busWrite;
  assign rdIn     = busSel && !busWrite;
  assign haltWrIn = wrIn && (busAddr[4:0] == 5'h00);
  assign irqWrIn  = wrIn && (busAddr[4:0] == 5'h08);
  assign txWrIn   = wrIn && (busAddr[4:0] == 5'h18);
  assign cpuRdIn  = rdIn && (busAddr[4:0] == 5'h04);
  assign cntRdIn  = rdIn && (busAddr[4:0] == 5'h0A);

  // R2: a halt write yields the pulse and the code on the next cycle
  a_r2_halt_after_write: assert property (@(posedge clk) disable iff (!rstN)
    haltWrIn |=> (haltPulse && haltCode == $past(busWdata[7:0])));

  // R2: no pulse without a halt write
  a_r2_no_stray_halt: assert property (@(posedge clk) disable iff (!rstN)
    haltPulse |-> $past(haltWrIn));

  // R7: transmit strobe carries the written byte
  a_r7_tx_after_write: assert property (@(posedge clk) disable iff (!rstN)
    txWrIn |=> (txStrobe && txData == $past(busWdata[7:0])));

  // R7: no strobe without an output write
  a_r7_no_stray_tx: assert property (@(posedge clk) disable iff (!rstN)
    txStrobe |-> $past(txWrIn));

  // R5: lines hold their level without an interrupt write
  a_r5_irq_hold: assert property (@(posedge clk) disable iff (!rstN)
    !irqWrIn |=> $stable(irqLines));

  // R8: upper read bytes are zero
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdIn |-> (busRdata[DATA_W-1:8] == '0));

  // R3: processor index read
  a_r3_cpu_index: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdIn |-> (busRdata[7:0] == 8'(reqCpu)));

  // R4: processor count read
  a_r4_cpu_count: assert property (@(posedge clk) disable iff (!rstN)
    cntRdIn |-> (busRdata[7:0] == 8'(NUM_CPU)));
endmodule

bind fw_glue_regs fw_glue_regs_chk #(
  .ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU), .BUS_BYTES(BUS_BYTES)
) uChk (.*);

// File: tb/fw_glue_regs_test.sv
module fw_glue_regs_test;
  localparam int ADDR_W = 8;
  localparam int NUM_CPU = 4;
  localparam int BUS_BYTES = 4;
  localparam int DATA_W = 32;
  localparam int CNT_W = 3;
  localparam int CPU_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [CNT_W-1:0] busBytes = 3'd4;
  logic [DATA_W-1:0] busWdata = '0;
  logic [CPU_W-1:0] reqCpu = '0;
  logic [DATA_W-1:0] busRdata;
  logic rxValid = 1'b0;
  logic [7:0] rxChar = '0;
  logic txStrobe;
  logic [7:0] txData;
  logic [NUM_CPU-1:0] irqLines;
  logic haltPulse;
  logic [7:0] haltCode;

  int vecCnt = 0;
  int errCnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fw_glue_regs #(.ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU), .BUS_BYTES(BUS_BYTES)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busBytes(busBytes), .busWdata(busWdata),
    .reqCpu(reqCpu), .busRdata(busRdata), .rxValid(rxValid), .rxChar(rxChar),
    .txStrobe(txStrobe), .txData(txData), .irqLines(irqLines),
    .haltPulse(haltPulse), .haltCode(haltCode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Write: drive at falling edge, held through one rising edge
  task automatic busWr(input logic [7:0] a, input logic [2:0] n, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busBytes = n; busWdata = d;
    @(posedge clk); #1;
  endtask

  task automatic busIdle();
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  // Read: sample combinational data before the edge, then let the edge act
  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a; busBytes = 3'd4;
    #1 d = busRdata;
    @(posedge clk); #1;
    busIdle();
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R9 irq", 32'(irqLines), 0);
    check("R9 tx strobe", 32'(txStrobe), 0);
    check("R9 halt pulse", 32'(haltPulse), 0);
    @(negedge clk); rstN = 1'b1;
    busRd(8'h1A, v); check("R9 out status", v, 32'h1);
    busRd(8'h10, v); check("R9 in data", v, 32'h0);
    busRd(8'h18, v); check("R9 out data", v, 32'h0);
  endtask

  task automatic testIdCount();
    logic [31:0] v;
    reqCpu = 2'd2; busRd(8'h04, v); check("R3 cpu id 2", v, 32'd2);
    reqCpu = 2'd3; busRd(8'h24, v); check("R1 R3 aliased cpu id", v, 32'd3);
    busRd(8'h0A, v); check("R4 count", v, 32'd4);
    busRd(8'hEA, v); check("R1 R4 aliased count", v, 32'd4);
  endtask

  task automatic testHalt();
    busWr(8'h00, 3'd4, 32'h1234_56A5);
    check("R2 halt pulse high", 32'(haltPulse), 1);
    check("R2 halt code", 32'(haltCode), 32'hA5);
    busIdle();
    @(posedge clk); #1;
    check("R2 halt pulse one cycle", 32'(haltPulse), 0);
    check("R2 halt code held", 32'(haltCode), 32'hA5);
  endtask

  task automatic testIrq();
    busWr(8'h08, 3'd2, 32'h0102); busIdle();
    check("R5 line 2 asserted", 32'(irqLines), 32'b0100);
    busWr(8'h08, 3'd2, 32'h0103); busIdle();
    check("R5 line 3 asserted, 2 held", 32'(irqLines), 32'b1100);
    busWr(8'h08, 3'd1, 32'h0503); busIdle();
    check("R5 single byte drives low", 32'(irqLines), 32'b0100);
    busWr(8'h08, 3'd2, 32'h0107); busIdle();
    check("R5 out of range line ignored", 32'(irqLines), 32'b0100);
    busWr(8'h08, 3'd2, 32'h0002); busIdle();
    check("R5 zero level", 32'(irqLines), 32'b0000);
  endtask

  task automatic testRx();
    logic [31:0] v;
    rxValid = 1'b1; rxChar = 8'h5A;
    busRd(8'h14, v); check("R6 status with char", v, 32'h1);
    rxValid = 1'b0; rxChar = 8'h00;
    busRd(8'h10, v); check("R6 latched char", v, 32'h5A);
    busRd(8'h14, v); check("R6 status empty", v, 32'h0);
    busRd(8'h10, v); check("R6 data cleared", v, 32'h0);
    busWr(8'h10, 3'd1, 32'h77); busIdle();
    busRd(8'h10, v); check("R10 in data written", v, 32'h77);
  endtask

  task automatic testTx();
    logic [31:0] v;
    busWr(8'h1A, 3'd1, 32'h0); busIdle();
    busRd(8'h1A, v); check("R10 out status written", v, 32'h0);
    busWr(8'h18, 3'd4, 32'hFFFF_FFC3);
    check("R7 strobe high", 32'(txStrobe), 1);
    check("R7 tx byte", 32'(txData), 32'hC3);
    busIdle();
    @(posedge clk); #1;
    check("R7 strobe one cycle", 32'(txStrobe), 0);
    busRd(8'h1A, v); check("R7 status set", v, 32'h1);
    busRd(8'h18, v); check("R7 R8 out data upper zero", v, 32'hC3);
  endtask

  task automatic testUndecoded();
    logic [31:0] v;
    busRd(8'h0C, v); check("R8 offset 0x0C", v, 0);
    busRd(8'h00, v); check("R8 offset 0x00", v, 0);
    busRd(8'h08, v); check("R8 offset 0x08", v, 0);
    busRd(8'h1C, v); check("R8 offset 0x1C", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    testIdCount();
    testHalt();
    testIrq();
    testRx();
    testTx();
    testUndecoded();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vecCnt++;
      errCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end
endmodule